// File: doc/BRIEF.md
# Serial-Bus Register Access Slave

This block is the two-wire serial bus (I2C) slave front end for a small register map. It watches the SCL and SDA lines through a synchroniser clocked by a faster system clock, finds START, repeated START and STOP conditions, and answers only to one fixed 7-bit device address. A master selects a register with a word-address byte. It then either writes a single data byte, or switches direction with a repeated START and streams bytes back out of the map.

A pointer holds the current register index. An address byte loads it, and each byte the slave sends moves it up by one. After the last location of the map, 2Fh, the pointer returns to 00h, so a long read wraps around the map. Writes go out on a one-cycle strobe on the register-file port. Reads come back from that port with one cycle of latency, which suits a block RAM. SDA is pulled low only through an open-drain enable, and that enable changes only while SCL is low.

Top module: `i2c_regport_slave`

## Requirements
- R1: After reset the SDA pull-down enable `sda_oe` is low and `reg_we` is low.
- R2: The identification byte (device address in bits 7:1, read flag in bit 0) is acknowledged only when bits 7:1 equal 1101111 (write byte DEh, read byte DFh). For any other address the slave leaves SDA released in the acknowledge clock, acknowledges no byte and writes nothing until the next START.
- R3: A write sequence acknowledges the identification byte, the word-address byte and the data byte (SDA low in each ninth clock). It raises `reg_we` for exactly one cycle, with `reg_waddr` set to the word address and `reg_wdata` set to the data byte.
- R4: Any byte after the single data byte of a write is not acknowledged and produces no write.
- R5: For a read sequence (identification byte with bit 0 = 0, word address, repeated START, identification byte with bit 0 = 1), all three bytes are acknowledged. The slave then shifts out, MSB first, the register at the word address.
- R6: The pointer advances by one for each byte sent. From 2Fh it goes to 00h.
- R7: When the master acknowledges (SDA low in the ninth clock), the next byte follows. When the master does not acknowledge, the slave keeps SDA released until the next START or STOP.
- R8: A read that begins directly with the read identification byte, with no word address, starts at the pointer value left by the previous transfer.
- R9: A START or STOP in the middle of a byte abandons the transfer without a write. The following transaction is served normally.
- R10: `sda_oe` changes only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than SCL |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Serial clock line as seen at the pad |
| sda_i | input | 1 | Serial data line as seen at the pad |
| sda_oe | output | 1 | When high, the pad pulls SDA low |
| reg_we | output | 1 | One-cycle register write strobe |
| reg_waddr | output | AW | Register index for the write |
| reg_wdata | output | 8 | Data for the write |
| reg_raddr | output | AW | Register index to read (current pointer) |
| reg_rdata | input | 8 | Read data, valid one clock after `reg_raddr` |

## Verification
The assertions assume that each SCL high or low phase lasts several system clocks longer than the synchroniser delay. They also assume that the master moves SDA only while SCL is low, except to form START or STOP, and that `reg_rdata` follows `reg_raddr` one clock later. The bench's bit-level master holds every SCL phase for a fixed number of system clocks and changes SDA only in the middle of a low phase. It models the bus as a wired-AND of its own drive and the slave's enable. It serves reads from a registered bench RAM with exactly one cycle of latency.

// File: rtl/i2c_rp_pkg.sv
package i2c_rp_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RX,
    ST_ACK_SET,
    ST_ACK_HOLD,
    ST_TX,
    ST_MACK,
    ST_MACK_END,
    ST_IGNORE
  } slv_state_t;

  typedef enum logic [1:0] {
    K_DEV,
    K_ADDR,
    K_DATA,
    K_EXTRA
  } byte_kind_t;
endpackage

// File: rtl/i2c_rp_sync.sv
module i2c_rp_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic [STAGES-1:0] scl_pipe;
  logic [STAGES-1:0] sda_pipe;
  logic scl_q;
  logic sda_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_pipe <= '1;
      sda_pipe <= '1;
      scl_q    <= 1'b1;
      sda_q    <= 1'b1;
    end else begin
      scl_pipe <= {scl_pipe[STAGES-2:0], scl_i};
      sda_pipe <= {sda_pipe[STAGES-2:0], sda_i};
      scl_q    <= scl_pipe[STAGES-1];
      sda_q    <= sda_pipe[STAGES-1];
    end
  end

  assign scl_s     = scl_pipe[STAGES-1];
  assign sda_s     = sda_pipe[STAGES-1];
  assign scl_rise  = scl_s & ~scl_q;
  assign scl_fall  = ~scl_s & scl_q;
  assign start_det = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_det  = scl_s & scl_q & ~sda_q & sda_s;
endmodule

// File: rtl/i2c_rp_ptr.sv
module i2c_rp_ptr #(
  parameter int          AW   = 8,
  parameter logic [AW-1:0] LAST = 8'h2F
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [AW-1:0] load_val,
  input  logic          inc,
  output logic [AW-1:0] ptr
);
  always_ff @(posedge clk) begin
    if (rst)       ptr <= '0;
    else if (load) ptr <= load_val;
    else if (inc)  ptr <= (ptr == LAST) ? '0 : ptr + 1'b1;
  end

  // R6
  ptr_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    (inc && !load && ptr == LAST) |=> (ptr == '0));

  // R6
  ptr_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!inc && !load) |=> $stable(ptr));
endmodule

// File: rtl/i2c_regport_slave.sv
module i2c_regport_slave
  import i2c_rp_pkg::*;
#(
  parameter int            AW       = 8,
  parameter logic [6:0]    DEV_ADDR = 7'b1101111,
  parameter logic [AW-1:0] PTR_LAST = 8'h2F,
  parameter int            SYNC_STG = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          scl_i,
  input  logic          sda_i,
  output logic          sda_oe,
  output logic          reg_we,
  output logic [AW-1:0] reg_waddr,
  output logic [7:0]    reg_wdata,
  output logic [AW-1:0] reg_raddr,
  input  logic [7:0]    reg_rdata
);
  localparam int BYTE_W = 8;
  localparam int CNT_W  = $clog2(BYTE_W);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(BYTE_W - 1);

  logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
  slv_state_t state;
  byte_kind_t kind;
  logic [CNT_W-1:0] bitcnt;
  logic [BYTE_W-1:0] sr;
  logic [BYTE_W-1:0] byte_in;
  logic rw;
  logic ptr_load, ptr_inc;
  logic [AW-1:0] ptr;

  i2c_rp_sync #(.STAGES(SYNC_STG)) u_sync (
    .clk(clk), .rst(rst), .scl_i(scl_i), .sda_i(sda_i),
    .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  assign byte_in  = {sr[BYTE_W-2:0], sda_s};
  assign ptr_load = (state == ST_RX) && scl_rise && (bitcnt == CNT_LAST) &&
                    (kind == K_ADDR) && !start_det && !stop_det;
  assign ptr_inc  = (state == ST_TX) && scl_fall && (bitcnt == CNT_LAST) &&
                    !start_det && !stop_det;

  i2c_rp_ptr #(.AW(AW), .LAST(PTR_LAST)) u_ptr (
    .clk(clk), .rst(rst), .load(ptr_load), .load_val(AW'(byte_in)),
    .inc(ptr_inc), .ptr(ptr)
  );

  assign reg_raddr = ptr;

  function automatic byte_kind_t next_kind(byte_kind_t k);
    case (k)
      K_DEV:   return K_ADDR;
      K_ADDR:  return K_DATA;
      default: return K_EXTRA;
    endcase
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      kind      <= K_DEV;
      bitcnt    <= '0;
      sr        <= '0;
      rw        <= 1'b0;
      sda_oe    <= 1'b0;
      reg_we    <= 1'b0;
      reg_waddr <= '0;
      reg_wdata <= '0;
    end else begin
      reg_we <= 1'b0;
      if (start_det) begin
        state  <= ST_RX;
        kind   <= K_DEV;
        bitcnt <= '0;
        sda_oe <= 1'b0;
      end else if (stop_det) begin
        state  <= ST_IDLE;
        sda_oe <= 1'b0;
      end else begin
        case (state)
          ST_RX: if (scl_rise) begin
            sr     <= byte_in;
            bitcnt <= bitcnt + 1'b1;
            if (bitcnt == CNT_LAST) begin
              case (kind)
                K_DEV: begin
                  if (byte_in[7:1] == DEV_ADDR) begin
                    rw    <= byte_in[0];
                    state <= ST_ACK_SET;
                  end else begin
                    state <= ST_IGNORE;
                  end
                end
                K_ADDR: state <= ST_ACK_SET;
                K_DATA: begin
                  reg_we    <= 1'b1;
                  reg_waddr <= ptr;
                  reg_wdata <= byte_in;
                  state     <= ST_ACK_SET;
                end
                default: state <= ST_IGNORE;
              endcase
            end
          end
          ST_ACK_SET: if (scl_fall) begin
            sda_oe <= 1'b1;
            state  <= ST_ACK_HOLD;
          end
          ST_ACK_HOLD: if (scl_fall) begin
            bitcnt <= '0;
            if (kind == K_DEV && rw) begin
              sr     <= reg_rdata;
              sda_oe <= ~reg_rdata[7];
              state  <= ST_TX;
            end else begin
              sda_oe <= 1'b0;
              kind   <= next_kind(kind);
              state  <= ST_RX;
            end
          end
          ST_TX: if (scl_fall) begin
            if (bitcnt == CNT_LAST) begin
              sda_oe <= 1'b0;
              state  <= ST_MACK;
            end else begin
              bitcnt <= bitcnt + 1'b1;
              sr     <= sr << 1;
              sda_oe <= ~sr[BYTE_W-2];
            end
          end
          ST_MACK: if (scl_rise) begin
            state <= sda_s ? ST_IGNORE : ST_MACK_END;
          end
          ST_MACK_END: if (scl_fall) begin
            bitcnt <= '0;
            sr     <= reg_rdata;
            sda_oe <= ~reg_rdata[7];
            state  <= ST_TX;
          end
          default: ;
        endcase
      end
    end
  end

  // R10
  oe_rise_scl_low_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(sda_oe) |-> !$past(scl_s));

  // R3
  we_single_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    reg_we |=> !reg_we);

  // R2
  ignore_released_chk: assert property (@(posedge clk) disable iff (rst)
    (state == ST_IGNORE) |-> !sda_oe);

  // R7
  master_nack_release_chk: assert property (@(posedge clk) disable iff (rst)
    (state == ST_MACK && scl_rise && sda_s && !start_det && !stop_det) |=> !sda_oe);

  // R9
  start_clears_oe_chk: assert property (@(posedge clk) disable iff (rst)
    start_det |=> (!sda_oe && !reg_we));
endmodule

// File: tb/tb_i2c_regport_slave.sv
module tb_i2c_regport_slave;
  localparam int Q = 6;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst = 1'b1;
  logic scl = 1'b1;
  logic sda_m = 1'b1;
  wire  sda_line;
  logic sda_oe, reg_we;
  logic [7:0] reg_waddr, reg_wdata, reg_raddr, reg_rdata;

  assign sda_line = sda_m & ~sda_oe;

  i2c_regport_slave dut (
    .clk(clk), .rst(rst), .scl_i(scl), .sda_i(sda_line), .sda_oe(sda_oe),
    .reg_we(reg_we), .reg_waddr(reg_waddr), .reg_wdata(reg_wdata),
    .reg_raddr(reg_raddr), .reg_rdata(reg_rdata)
  );

  logic [7:0] mem [0:255];
  logic [7:0] exp_mem [0:255];
  logic       tb_we = 1'b0;
  logic [7:0] tb_a = '0, tb_d = '0;
  int tests = 0, fails = 0, we_cnt = 0, viol = 0;
  logic oe_prev = 1'b0;
  bit done = 0;

  always @(posedge clk) begin
    if (tb_we) mem[tb_a] <= tb_d;
    else if (reg_we) mem[reg_waddr] <= reg_wdata;
    reg_rdata <= mem[reg_raddr];
  end

  always @(posedge clk) begin
    #1;
    if (reg_we) we_cnt++;
    if (sda_oe !== oe_prev && scl) viol++;
    oe_prev = sda_oe;
  end

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  task automatic wq();
    repeat (Q) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; wq(); scl = 1'b1; wq(); sda_m = 1'b0; wq(); scl = 1'b0; wq();
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; wq(); scl = 1'b1; wq(); sda_m = 1'b1; wq();
  endtask

  task automatic clock_bit(input logic b, output logic r);
    sda_m = b; wq(); scl = 1'b1; wq(); r = sda_line; wq(); scl = 1'b0; wq();
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    logic r;
    for (int i = 7; i >= 0; i--) clock_bit(b[i], r);
    clock_bit(1'b1, r);
    ack = ~r;
  endtask

  task automatic read_byte(input logic mack, output logic [7:0] d);
    logic r;
    for (int i = 7; i >= 0; i--) begin
      clock_bit(1'b1, r);
      d[i] = r;
    end
    clock_bit(~mack, r);
  endtask

  function automatic logic [7:0] nxt(input logic [7:0] p);
    return (p == 8'h2F) ? 8'h00 : p + 8'h01;
  endfunction

  // R5 R6 R7: read n bytes from start address a, NACK the last
  task automatic do_read(input logic [7:0] a, input int n);
    logic ack1, ack2, ack3, r;
    logic [7:0] d, p;
    bit quiet;
    bus_start(); send_byte(8'hDE, ack1); send_byte(a, ack2);
    bus_start(); send_byte(8'hDF, ack3);
    chk(ack1 && ack2 && ack3, "R5 setup acks", {ack1, ack2, ack3}, 3'b111);
    p = a;
    for (int i = 0; i < n; i++) begin
      read_byte(i < n - 1, d);
      chk(d == exp_mem[p], "R6 read data", d, exp_mem[p]);
      p = nxt(p);
    end
    quiet = 1;
    for (int i = 0; i < 9; i++) begin
      clock_bit(1'b1, r);
      if (!r) quiet = 0;
    end
    chk(quiet, "R7 released after NACK", quiet, 1);
    bus_stop();
  endtask

  initial begin
    logic a1, a2, a3, a4;
    logic [7:0] d;
    int wc;
    repeat (3) @(negedge clk);
    for (int i = 0; i < 256; i++) begin
      tb_we = 1'b1; tb_a = 8'(i); tb_d = 8'((i * 5 + 3) & 255);
      exp_mem[i] = 8'((i * 5 + 3) & 255);
      @(negedge clk);
    end
    tb_we = 1'b0;
    rst = 1'b0;
    repeat (4) @(negedge clk);
    chk(sda_oe == 1'b0 && reg_we == 1'b0, "R1 reset outputs", {sda_oe, reg_we}, 0);

    // R2: sweep every 7-bit address
    for (int a = 0; a < 128; a++) begin
      bus_start(); send_byte({7'(a), 1'b0}, a1); bus_stop();
      chk(a1 == (a == 7'h6F), "R2 address match", a1, (a == 7'h6F));
    end

    // R2: wrong address, following bytes ignored
    wc = we_cnt;
    bus_start(); send_byte(8'hA0, a1); send_byte(8'h05, a2); send_byte(8'h99, a3); bus_stop();
    chk(!a1 && !a2 && !a3, "R2 ignored bytes NACKed", {a1, a2, a3}, 0);
    chk(we_cnt == wc && mem[5] == exp_mem[5], "R2 no write", we_cnt - wc, 0);

    // R3: write sweep over the whole map
    for (int a = 0; a < 48; a++) begin
      d = 8'(a) ^ 8'hA5 ^ 8'(a << 2);
      wc = we_cnt;
      bus_start(); send_byte(8'hDE, a1); send_byte(8'(a), a2); send_byte(d, a3); bus_stop();
      exp_mem[a] = d;
      chk(a1 && a2 && a3, "R3 write acks", {a1, a2, a3}, 3'b111);
      chk(mem[a] == d && we_cnt == wc + 1, "R3 written value", mem[a], d);
    end

    // R4: extra byte after data
    wc = we_cnt;
    bus_start(); send_byte(8'hDE, a1); send_byte(8'h10, a2); send_byte(8'h3C, a3);
    send_byte(8'hC3, a4); bus_stop();
    exp_mem[16] = 8'h3C;
    chk(a1 && a2 && a3 && !a4, "R4 extra byte NACKed", {a1, a2, a3, a4}, 4'b1110);
    chk(mem[16] == 8'h3C && mem[17] == exp_mem[17] && we_cnt == wc + 1,
        "R4 single write", mem[17], exp_mem[17]);

    // R5 R6: long read crossing the wrap, short reads
    do_read(8'h00, 50);
    do_read(8'h14, 1);
    do_read(8'h2E, 4);

    // R8: read from the retained pointer (2Eh + 4 sent -> 02h)
    bus_start(); send_byte(8'hDF, a1);
    chk(a1, "R8 read id ack", a1, 1);
    read_byte(1'b1, d); chk(d == exp_mem[2], "R8 pointer continues", d, exp_mem[2]);
    read_byte(1'b0, d); chk(d == exp_mem[3], "R8 pointer continues", d, exp_mem[3]);
    bus_stop();

    // R9: START in the middle of the address byte, then a full write
    wc = we_cnt;
    bus_start(); send_byte(8'hDE, a1);
    for (int i = 0; i < 4; i++) clock_bit(1'b0, a4);
    bus_start(); send_byte(8'hDE, a1); send_byte(8'h07, a2); send_byte(8'h66, a3); bus_stop();
    exp_mem[7] = 8'h66;
    chk(a1 && a2 && a3 && mem[7] == 8'h66 && we_cnt == wc + 1,
        "R9 start abort then write", mem[7], 8'h66);
    // R9: STOP in the middle of a data byte, no write
    wc = we_cnt;
    bus_start(); send_byte(8'hDE, a1); send_byte(8'h08, a2);
    for (int i = 0; i < 3; i++) clock_bit(1'b1, a4);
    bus_stop();
    chk(we_cnt == wc && mem[8] == exp_mem[8], "R9 stop abort no write", we_cnt - wc, 0);
    do_read(8'h07, 2);

    // R10
    chk(viol == 0, "R10 enable changes with SCL low", viol, 0);

    if (!done) begin
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      done = 1;
      tests++; fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 190000, 0);
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule